// File: doc/BRIEF.md
# Dual-Output Fast-Read Serializer

This block is the read data path of a serial flash slave. An upstream receiver shifts in the opcode and the address. On the system clock cycle in which the last address bit is sampled, it hands both to this block with a one-cycle `cmd_valid_i` pulse. The block decides how the rest of the read is framed. A plain read puts data out on the very next falling serial-clock edge. A fast read first lets a fixed number of dummy clocks pass. The dual-output fast read also sends two bits per clock, one on the dedicated output pin and one on the shared bidirectional pin.

Serial-clock falling edges arrive as single-cycle strobes on `sck_fall_i`, already synchronised to `clk_i`. The strobes are at least four system cycles apart, and the first one comes no sooner than two cycles after `cmd_valid_i`. Array bytes come from a memory port with a fixed one-cycle latency. The block asks for the next byte as soon as the current one enters the shifter, so the output never waits. The address counts up by one per byte and wraps at the top of the array. Streaming goes on until chip-select is released.

Top module: `flash_dual_read`

## Requirements
- R1: Opcode 03h (plain read) drives bit 7 of the first byte on `so_o` after the first `sck_fall_i` strobe that follows the accepted command. Each later strobe moves to the next lower bit, most significant first, 8 strobes per byte.
- R2: Opcode 0Bh (fast read) lets `DUMMY_CYC` (default 8) strobes pass with both output enables low. It then sends single-bit data as in R1, starting on the next strobe.
- R3: Opcode 3Bh (dual read) lets the same dummy strobes pass and then sends one byte per 4 strobes. `so_o` carries bits 7, 5, 3, 1 and `sio_o` carries bits 6, 4, 2, 0, in that order.
- R4: `so_oe_o` rises on the first data strobe of every accepted read. `sio_oe_o` rises on that same strobe, but only for opcode 3Bh, and is never high without `so_oe_o`.
- R5: Consecutive bytes come from consecutive addresses, starting at `cmd_addr_i`, for as long as chip-select stays low.
- R6: After address 2^MEM_AW-1 the next byte is read from address 0.
- R7: A command offered while `busy_i` is high is ignored: no memory request is made and both output enables stay low.
- R8: Any opcode other than 03h, 0Bh and 3Bh is ignored, with no memory request and no output enable.
- R9: When `cs_n_i` is high, both output enables are low in the same cycle. A read cut short in mid-byte leaves no state behind, and the next command starts afresh.
- R10: An accepted read issues exactly one request for the command address when it is accepted, plus one request per byte loaded into the shifter. Pin values change only in the cycle after a `sck_fall_i` strobe.
- R11: During reset, both output enables and `mem_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Chip-select, active low |
| sck_fall_i | input | 1 | One-cycle strobe per serial-clock falling edge |
| cmd_valid_i | input | 1 | Opcode and address valid, aligned with the last address bit |
| cmd_op_i | input | 8 | Received opcode |
| cmd_addr_i | input | MEM_AW | Low bits of the received 24-bit address |
| busy_i | input | 1 | A program or erase cycle is in progress |
| mem_req_o | output | 1 | Byte read request to the array |
| mem_addr_o | output | MEM_AW | Byte address of the request |
| mem_rdata_i | input | 8 | Array data, valid the cycle after the request |
| so_o | output | 1 | Value for the dedicated output pin |
| so_oe_o | output | 1 | Output enable of the dedicated output pin |
| sio_o | output | 1 | Value for the shared bidirectional pin |
| sio_oe_o | output | 1 | Output enable of the shared bidirectional pin |

## Verification
The three read opcodes are each streamed over several bytes from unrelated start addresses. The pin-by-pin comparison therefore separates a wrong dummy count, a swapped even/odd pin assignment and a wrong bit order. Reads that start one and two bytes below the top of the array, in single and dual mode, show whether the address wraps or runs on. A busy command and two foreign opcodes check that nothing is fetched and nothing is driven. A plain read cut off after three bits, followed at once by a dual read, shows that the shifter and the dummy counter restart cleanly. The request count after each read checks the prefetch of exactly one byte ahead.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_FAST = 8'h0B;
  localparam logic [7:0] OP_DUAL = 8'h3B;

  typedef enum logic [1:0] {PH_IDLE, PH_DUMMY, PH_LEAD, PH_STREAM} phase_e;

  typedef struct packed {
    logic ok;
    logic dual;
    logic dummy;
  } rd_mode_t;
endpackage

// File: rtl/flash_rd_decode.sv
module flash_rd_decode
  import flash_rd_pkg::*;
(
  input  logic [7:0] op_i,
  output rd_mode_t   mode_o
);
  always_comb begin
    mode_o = '0;
    case (op_i)
      OP_READ: mode_o.ok = 1'b1;
      OP_FAST: begin
        mode_o.ok    = 1'b1;
        mode_o.dummy = 1'b1;
      end
      OP_DUAL: begin
        mode_o.ok    = 1'b1;
        mode_o.dummy = 1'b1;
        mode_o.dual  = 1'b1;
      end
      default: mode_o = '0;
    endcase
  end
endmodule

// File: rtl/flash_rd_fetch.sv
module flash_rd_fetch #(
  parameter int MEM_AW = 23
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MEM_AW-1:0] start_addr_i,
  input  logic              adv_i,
  output logic              mem_req_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  input  logic [7:0]        mem_rdata_i,
  output logic [7:0]        hold_o
);
  localparam logic [MEM_AW-1:0] ONE = MEM_AW'(1);

  logic [MEM_AW-1:0] next_q;
  logic              rvld_q;
  logic [7:0]        hold_q;

  assign mem_req_o  = start_i | adv_i;
  assign mem_addr_o = start_i ? start_addr_i : next_q;
  assign hold_o     = hold_q;

  // address field is exactly MEM_AW wide, so +1 wraps at the array top
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_q <= '0;
      rvld_q <= 1'b0;
      hold_q <= '0;
    end else begin
      rvld_q <= mem_req_o;
      if (mem_req_o) next_q <= mem_addr_o + ONE;
      if (rvld_q) hold_q <= mem_rdata_i;
    end
  end
endmodule

// File: rtl/flash_rd_shift.sv
module flash_rd_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic       step_i,
  input  logic       dual_i,
  input  logic [7:0] data_i,
  output logic       hi_o,
  output logic       lo_o,
  output logic       last_o
);
  logic [7:0] sh_q;
  logic [2:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= data_i;
      cnt_q <= dual_i ? 3'd3 : 3'd7;
    end else if (step_i) begin
      sh_q  <= dual_i ? {sh_q[5:0], 2'b00} : {sh_q[6:0], 1'b0};
      cnt_q <= cnt_q - 3'd1;
    end
  end

  assign hi_o   = sh_q[7];
  assign lo_o   = sh_q[6];
  assign last_o = (cnt_q == 3'd0);
endmodule

// File: rtl/flash_dual_read.sv
module flash_dual_read
  import flash_rd_pkg::*;
#(
  parameter int MEM_AW    = 23,
  parameter int DUMMY_CYC = 8,
  localparam int DCW      = $clog2(DUMMY_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              sck_fall_i,
  input  logic              cmd_valid_i,
  input  logic [7:0]        cmd_op_i,
  input  logic [MEM_AW-1:0] cmd_addr_i,
  input  logic              busy_i,
  output logic              mem_req_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              sio_o,
  output logic              sio_oe_o
);
  phase_e         ph_q;
  logic           dual_q;
  logic [DCW-1:0] dcnt_q;
  logic           so_oe_q, sio_oe_q;
  rd_mode_t       mode;
  logic           active, start, fall, first_ld, next_ld, step, last;
  logic [7:0]     hold;

  flash_rd_decode u_dec (.op_i(cmd_op_i), .mode_o(mode));

  assign active   = (ph_q != PH_IDLE);
  assign start    = !cs_n_i && !active && cmd_valid_i && !busy_i && mode.ok;
  assign fall     = sck_fall_i && !cs_n_i;
  assign first_ld = fall && (ph_q == PH_LEAD || (ph_q == PH_DUMMY && dcnt_q == '0));
  assign next_ld  = fall && ph_q == PH_STREAM && last;
  assign step     = fall && ph_q == PH_STREAM && !last;

  flash_rd_fetch #(.MEM_AW(MEM_AW)) u_fetch (
    .clk_i, .rst_ni,
    .start_i     (start),
    .start_addr_i(cmd_addr_i),
    .adv_i       (first_ld | next_ld),
    .mem_req_o,
    .mem_addr_o,
    .mem_rdata_i,
    .hold_o      (hold)
  );

  flash_rd_shift u_shift (
    .clk_i, .rst_ni,
    .load_i(first_ld | next_ld),
    .step_i(step),
    .dual_i(dual_q),
    .data_i(hold),
    .hi_o  (so_o),
    .lo_o  (sio_o),
    .last_o(last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q     <= PH_IDLE;
      dual_q   <= 1'b0;
      dcnt_q   <= '0;
      so_oe_q  <= 1'b0;
      sio_oe_q <= 1'b0;
    end else if (cs_n_i) begin
      ph_q     <= PH_IDLE;
      so_oe_q  <= 1'b0;
      sio_oe_q <= 1'b0;
    end else begin
      if (start) begin
        ph_q   <= mode.dummy ? PH_DUMMY : PH_LEAD;
        dual_q <= mode.dual;
        dcnt_q <= DCW'(DUMMY_CYC);
      end else if (fall && ph_q == PH_DUMMY && dcnt_q != '0) begin
        dcnt_q <= dcnt_q - DCW'(1);
      end
      if (first_ld) begin
        ph_q     <= PH_STREAM;
        so_oe_q  <= 1'b1;
        sio_oe_q <= dual_q;
      end
    end
  end

  // enables drop in the deselect cycle itself, not one edge later
  assign so_oe_o  = so_oe_q & ~cs_n_i;
  assign sio_oe_o = sio_oe_q & ~cs_n_i;
endmodule

// File: rtl/flash_dual_read_chk.sv
module flash_dual_read_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_n_i,
  input logic sck_fall_i,
  input logic cmd_valid_i,
  input logic busy_i,
  input logic active_i,
  input logic mem_req_o,
  input logic so_o,
  input logic so_oe_o,
  input logic sio_o,
  input logic sio_oe_o
);
  // R9
  oe_off_deselected_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |-> (!so_oe_o && !sio_oe_o));

  // R4
  sio_needs_so_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sio_oe_o |-> so_oe_o);

  // R4
  oe_rise_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(so_oe_o) |-> $past(sck_fall_i));

  // R10
  req_on_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (cmd_valid_i || sck_fall_i));

  // R10
  pins_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sck_fall_i) |-> ($stable(so_o) && $stable(sio_o)));

  // R7
  busy_no_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && busy_i && !active_i) |-> !mem_req_o);
endmodule

bind flash_dual_read flash_dual_read_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_n_i     (cs_n_i),
  .sck_fall_i (sck_fall_i),
  .cmd_valid_i(cmd_valid_i),
  .busy_i     (busy_i),
  .active_i   (active),
  .mem_req_o  (mem_req_o),
  .so_o       (so_o),
  .so_oe_o    (so_oe_o),
  .sio_o      (sio_o),
  .sio_oe_o   (sio_oe_o)
);

// File: tb/flash_dual_read_tb.sv
module flash_dual_read_tb;
  localparam int AW = 23;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1;
  logic          sck_fall = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [7:0]    cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic          busy = 1'b0;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_rdata = '0;
  logic          so, so_oe, sio, sio_oe;

  int n_chk = 0;
  int n_fail = 0;
  logic [AW-1:0] req_q[$];

  always #5 clk = ~clk;

  flash_dual_read u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .sck_fall_i(sck_fall),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_addr_i(cmd_addr),
    .busy_i(busy), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rdata_i(mem_rdata), .so_o(so), .so_oe_o(so_oe), .sio_o(sio),
    .sio_oe_o(sio_oe)
  );

  function automatic logic [7:0] fdat(input logic [AW-1:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ {1'b0, a[22:16]} ^ 8'hA5;
  endfunction

  // memory model: one-cycle latency
  always @(posedge clk) begin
    if (mem_req) begin
      mem_rdata <= fdat(mem_addr);
      req_q.push_back(mem_addr);
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // reference model: expected pin values per falling strobe
  task automatic run(input logic [7:0] op, input logic [AW-1:0] a, input int nf,
                     input logic bsy, input string tag);
    int base, dm, per, loaded;
    logic dl, ok;
    base = req_q.size();
    dl   = (op == 8'h3B);
    ok   = !bsy && (op == 8'h03 || op == 8'h0B || op == 8'h3B);
    dm   = (op == 8'h03) ? 0 : 8;
    per  = dl ? 4 : 8;
    cs_n = 1'b0; busy = bsy;
    tick(); tick();
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
    tick();
    cmd_valid = 1'b0;
    tick(); tick();
    for (int k = 1; k <= nf; k++) begin
      sck_fall = 1'b1;
      tick();
      sck_fall = 1'b0;
      tick();
      if (!ok || k <= dm) begin
        chk({tag, " enables idle (R2 R7 R8)"}, {30'd0, so_oe, sio_oe}, 32'd0);
      end else begin
        int j, b, p;
        logic [7:0] d;
        j = k - dm - 1;
        b = j / per;
        p = j % per;
        d = fdat(a + AW'(b));
        if (dl) chk({tag, " dual pins (R3 R4 R5)"}, {28'd0, so_oe, sio_oe, so, sio},
                    {28'd0, 2'b11, d[7-2*p], d[6-2*p]});
        else    chk({tag, " single pin (R1 R4 R5)"}, {29'd0, so_oe, sio_oe, so},
                    {29'd0, 2'b10, d[7-p]});
      end
      tick(); tick(); tick();
    end
    cs_n = 1'b1;
    #1;
    chk({tag, " deselect drops enables (R9)"}, {30'd0, so_oe, sio_oe}, 32'd0);
    tick(); tick();
    busy = 1'b0;
    loaded = (ok && nf > dm) ? (nf - dm + per - 1) / per : 0;
    chk({tag, " request count (R10)"}, 32'(req_q.size() - base), ok ? 32'(loaded + 1) : 32'd0);
    if (ok) chk({tag, " first request address (R10)"}, 32'(req_q[base]), 32'(a));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick();
    // R11 reset state
    chk("R11 reset outputs", {29'd0, so_oe, sio_oe, mem_req}, 32'd0);
    tick();
    rst_n = 1'b1;
    tick(); tick();
    run(8'h03, 23'h000100, 24, 1'b0, "R1 plain");
    run(8'h0B, 23'h012345, 24, 1'b0, "R2 fast");
    run(8'h3B, 23'h0ABCDE, 24, 1'b0, "R3 dual");
    run(8'h3B, 23'h7FFFFE, 24, 1'b0, "R6 dual wrap");
    run(8'h0B, 23'h7FFFFF, 24, 1'b0, "R6 fast wrap");
    run(8'h3B, 23'h001000, 12, 1'b1, "R7 busy");
    run(8'h02, 23'h000200, 12, 1'b0, "R8 op02");
    run(8'h05, 23'h000300, 12, 1'b0, "R8 op05");
    run(8'h03, 23'h055555, 11, 1'b0, "R9 abort");
    run(8'h3B, 23'h02AAAA, 16, 1'b0, "R9 restart");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule